// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates among eight interrupt request lines. Each line is captured into a pending-request register, either as a level (the bit follows the input) or as a rising edge (the bit latches until the request is taken). A software-written mask hides lines from arbitration. An in-service register records which requests are being handled. A rotating priority base decides which line counts as most urgent: line `base` has rank 0, line `base+1` has rank 1, and so on, modulo 8.

The lowest-ranked pending, unmasked line is the candidate. The interrupt output rises only when the candidate outranks every line currently in service. Two configuration inputs alter that comparison. Special mask removes masked lines from the in-service set. Special nesting, on a master unit, ignores the in-service bit of the cascade line.

An acknowledge strobe moves the winner into service, or, under automatic end-of-interrupt, optionally rotates the base past it instead. End-of-interrupt commands retire in-service bits and can rotate the base. A separate command sets the base directly.

Top module: `irq_rotor`

## Requirements
- R1: While reset is asserted and after its release with no stimulus, the request, in-service and mask registers, the priority base and the remembered input levels are all zero, and `int_out` is low.
- R2: The candidate is the first set bit of `irr_q & ~mask_q`, scanning lines `base_q`, `base_q+1`, ... modulo 8. `win_line` is that line number whenever `win_valid` is high.
- R3: `int_out` and `win_valid` are high exactly when the candidate's rank is strictly smaller than the rank of the first set bit of the effective in-service set. An empty set has rank 8.
- R4: With `spec_mask` high, masked lines are removed from the effective in-service set before the comparison.
- R5: With `spec_nest` high and parameter `IS_MASTER` nonzero, in-service bit `CASCADE_LINE` (default 2) is left out of the comparison.
- R6: A line is level-sensitive when `level_all` or its `level_sel` bit is 1. Its request bit then equals the input value sampled at the previous rising clock edge.
- R7: An edge-sensitive line sets its request bit at a clock edge where the input is 1 and the level remembered from the previous edge was 0. A falling input only updates the remembered level. The bit otherwise holds until acknowledged.
- R8: `ack` acts only while `win_valid` is high. Without `auto_eoi` it sets the in-service bit of `win_line`. With `auto_eoi` it sets no in-service bit, and if `rot_aeoi` is also high the base becomes `win_line+1` modulo 8. An `ack` while `win_valid` is low changes nothing.
- R9: A taken acknowledge clears the winner's request bit only if that line is edge-sensitive.
- R10: `mask_we` loads `mask_wdata` into the mask register at the clock edge.
- R11: `eoi` with `eoi_specific` low clears the in-service bit of lowest rank relative to the base, with no masking applied to that choice. With `eoi_specific` high it clears bit `eoi_line`. With `eoi_rotate` high, the base becomes the cleared line + 1 modulo 8. A non-specific `eoi` with an empty in-service set changes nothing.
- R12: `prio_set` sets the base to `prio_line+1` modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 8 | Interrupt request lines |
| level_all | input | 1 | Treat every line as level-sensitive |
| level_sel | input | 8 | Per-line level-sensitive select |
| auto_eoi | input | 1 | Acknowledge does not enter service |
| rot_aeoi | input | 1 | Rotate base on acknowledge under auto EOI |
| spec_mask | input | 1 | Masked lines leave the in-service comparison |
| spec_nest | input | 1 | Ignore the cascade line's in-service bit |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_specific | input | 1 | EOI targets `eoi_line` instead of the lowest rank |
| eoi_rotate | input | 1 | EOI also moves the base past the cleared line |
| eoi_line | input | 3 | Line for a specific EOI |
| prio_set | input | 1 | Set the base directly |
| prio_line | input | 3 | Line that becomes lowest priority |
| int_out | output | 1 | Interrupt request to the processor |
| win_line | output | 3 | Winning line number |
| win_valid | output | 1 | `win_line` is meaningful |
| irr_q | output | 8 | Pending request register |
| isr_q | output | 8 | In-service register |
| mask_q | output | 8 | Mask register |
| base_q | output | 3 | Rotating priority base |

## Verification
`int_out`, `win_valid` and `win_line` are combinational in the registers and the two comparison mode inputs, so they are due in the same cycle as the state they depend on. Every effect of `req_in`, `ack`, `eoi`, `prio_set` and `mask_we` on `irr_q`, `isr_q`, `mask_q` and `base_q` is due after exactly one rising edge. The bench therefore drives all inputs at a falling edge and compares every output at the next falling edge against a model stepped once per cycle. Mode inputs are changed only at falling edges, so the combinational outputs are compared against the modes that are actually applied.

// File: rtl/irq_rotor.sv
module irq_rotor #(
  parameter int N            = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int LW          = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic          level_all,
  input  logic [N-1:0]  level_sel,
  input  logic          auto_eoi,
  input  logic          rot_aeoi,
  input  logic          spec_mask,
  input  logic          spec_nest,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          ack,
  input  logic          eoi,
  input  logic          eoi_specific,
  input  logic          eoi_rotate,
  input  logic [LW-1:0] eoi_line,
  input  logic          prio_set,
  input  logic [LW-1:0] prio_line,
  output logic          int_out,
  output logic [LW-1:0] win_line,
  output logic          win_valid,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  mask_q,
  output logic [LW-1:0] base_q
);
  localparam int PW = LW + 1;

  logic [N-1:0]  irr, isr, mask, last;
  logic [LW-1:0] base;

  // rank of the first set bit scanning upward from b, N when empty (N is a power of two)
  function automatic logic [PW-1:0] first_from(input logic [N-1:0] v, input logic [LW-1:0] b);
    logic [LW-1:0] idx;
    first_from = PW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      idx = b + LW'(k);
      if (v[idx]) first_from = PW'(k);
    end
  endfunction

  logic [N-1:0]  cand, svc, level, hit, eoi_clr;
  logic [PW-1:0] p_cand, p_svc, p_isr;
  logic [LW-1:0] eoi_tgt;
  logic          take, eoi_go;

  always_comb begin
    cand = irr & ~mask;
    svc  = isr;
    if (spec_mask) svc = svc & ~mask;
    if (spec_nest && IS_MASTER) svc[CASCADE_LINE] = 1'b0;
  end

  assign p_cand    = first_from(cand, base);
  assign p_svc     = first_from(svc, base);
  assign win_valid = p_cand < p_svc;
  assign win_line  = base + p_cand[LW-1:0];
  assign int_out   = win_valid;

  assign level = {N{level_all}} | level_sel;
  assign take  = ack & win_valid;
  assign hit   = N'(take) << win_line;

  assign p_isr   = first_from(isr, base);
  assign eoi_tgt = eoi_specific ? eoi_line : base + p_isr[LW-1:0];
  assign eoi_go  = eoi & (eoi_specific | ~p_isr[LW]);
  assign eoi_clr = N'(eoi_go) << eoi_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr  <= '0;
      isr  <= '0;
      mask <= '0;
      last <= '0;
      base <= '0;
    end else begin
      irr  <= (level & req_in) | (~level & ((irr & ~hit) | (req_in & ~last)));
      last <= req_in;
      if (mask_we) mask <= mask_wdata;
      isr  <= (isr & ~eoi_clr) | (auto_eoi ? '0 : hit);
      if (take && auto_eoi && rot_aeoi) base <= win_line + 1'b1;
      else if (eoi_go && eoi_rotate)    base <= eoi_tgt + 1'b1;
      else if (prio_set)                base <= prio_line + 1'b1;
    end
  end

  assign irr_q  = irr;
  assign isr_q  = isr;
  assign mask_q = mask;
  assign base_q = base;
endmodule

module irq_rotor_chk #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_in,
  input logic          level_all,
  input logic [N-1:0]  level_sel,
  input logic          auto_eoi,
  input logic          rot_aeoi,
  input logic          eoi,
  input logic          ack,
  input logic          win_valid,
  input logic [LW-1:0] win_line,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  mask_q,
  input logic [LW-1:0] base_q
);
  logic seen;
  logic [N-1:0] lvl;
  assign lvl = {N{level_all}} | level_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (irr_q[win_line] && !mask_q[win_line])); // R2

  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && !auto_eoi && !eoi) |=> isr_q[$past(win_line)]); // R8

  AST_AEOI_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_valid && auto_eoi && rot_aeoi) |=> (base_q == LW'($past(win_line) + 1'b1))); // R8

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((irr_q & $past(lvl)) == ($past(req_in) & $past(lvl)))); // R6

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(ack)) |-> ((irr_q & $past(irr_q & ~lvl)) == $past(irr_q & ~lvl))); // R7

  AST_SERVICE_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(ack)) |-> ((isr_q & ~$past(isr_q)) == '0)); // R8
endmodule

bind irq_rotor irq_rotor_chk #(.N(N)) u_chk (.*);

// File: tb/sim_irq_rotor.sv
`timescale 1ns/1ps
module sim_irq_rotor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, level_sel = '0, mask_wdata = '0;
  logic       level_all = 0, auto_eoi = 0, rot_aeoi = 0, spec_mask = 0, spec_nest = 0;
  logic       mask_we = 0, ack = 0, eoi = 0, eoi_specific = 0, eoi_rotate = 0, prio_set = 0;
  logic [2:0] eoi_line = '0, prio_line = '0;
  logic       int_out, win_valid;
  logic [2:0] win_line, base_q;
  logic [7:0] irr_q, isr_q, mask_q;

  int nchk = 0, nbad = 0;
  bit done = 0;

  logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_last = '0;
  logic [2:0] m_base = '0;

  always #2.5 clk = ~clk;

  irq_rotor u0 (.*);

  function automatic int rank_of(input logic [7:0] v, input logic [2:0] b);
    for (int k = 0; k < 8; k++) if (v[3'(b + 3'(k))]) return k;
    return 8;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected combinational outputs from model state and current modes (R2 R3 R4 R5)
  function automatic logic exp_valid();
    logic [7:0] s;
    s = m_isr;
    if (spec_mask) s = s & ~m_mask;
    if (spec_nest) s[2] = 1'b0;
    return rank_of(m_irr & ~m_mask, m_base) < rank_of(s, m_base);
  endfunction

  function automatic logic [2:0] exp_line();
    return 3'(m_base + 3'(rank_of(m_irr & ~m_mask, m_base)));
  endfunction

  task automatic compare_all();
    logic ev;
    ev = exp_valid();
    chk("R3 R4 R5 int_out", int'(int_out), int'(ev));
    chk("R3 win_valid", int'(win_valid), int'(ev));
    if (ev) chk("R2 win_line", int'(win_line), int'(exp_line()));
    chk("R6 R7 R9 irr", int'(irr_q), int'(m_irr));
    chk("R8 R11 isr", int'(isr_q), int'(m_isr));
    chk("R10 mask", int'(mask_q), int'(m_mask));
    chk("R8 R11 R12 base", int'(base_q), int'(m_base));
  endtask

  // model step for one rising edge using the inputs now driven
  task automatic model_step();
    logic [7:0] lvl, hit, n_isr;
    logic [2:0] n_base, w;
    logic take;
    int p;
    lvl  = {8{level_all}} | level_sel;
    take = ack && exp_valid();
    w    = exp_line();
    hit  = take ? (8'd1 << w) : 8'd0;
    n_isr  = m_isr;
    n_base = m_base;
    if (eoi) begin
      if (eoi_specific) begin
        n_isr[eoi_line] = 1'b0;
        if (eoi_rotate) n_base = eoi_line + 3'd1;
      end else begin
        p = rank_of(m_isr, m_base);
        if (p < 8) begin
          n_isr[3'(m_base + 3'(p))] = 1'b0;
          if (eoi_rotate) n_base = 3'(m_base + 3'(p) + 3'd1);
        end
      end
    end
    if (take) begin
      if (!auto_eoi) n_isr = n_isr | hit;
      else if (rot_aeoi) n_base = w + 3'd1;
    end
    if (prio_set) n_base = prio_line + 3'd1;
    m_irr  = (lvl & req_in) | (~lvl & ((m_irr & ~hit) | (req_in & ~m_last)));
    m_last = req_in;
    if (mask_we) m_mask = mask_wdata;
    m_isr  = n_isr;
    m_base = n_base;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    chk("R1 reset int_out", int'(int_out), 0);
    chk("R1 reset irr", int'(irr_q), 0);
    chk("R1 reset isr", int'(isr_q), 0);
    chk("R1 reset mask", int'(mask_q), 0);
    chk("R1 reset base", int'(base_q), 0);
    rst_n = 1'b1;
    cycle();

    // directed: edge line 5 captured, spurious ack ignored first (R7 R8)
    ack = 1; model_step(); cycle(); ack = 0;
    req_in = 8'h20; model_step(); cycle();
    req_in = 8'h00; model_step(); cycle();
    // ack takes line 5 into service, clears edge request (R8 R9)
    ack = 1; model_step(); cycle(); ack = 0;
    // non-specific EOI with rotation (R11)
    eoi = 1; eoi_rotate = 1; model_step(); cycle(); eoi = 0; eoi_rotate = 0;
    // non-specific EOI on empty in-service set (R11)
    eoi = 1; eoi_rotate = 1; model_step(); cycle(); eoi = 0; eoi_rotate = 0;
    // direct base set (R12)
    prio_set = 1; prio_line = 3'd6; model_step(); cycle(); prio_set = 0;

    for (int ph = 0; ph < 12; ph++) begin
      level_all = ($urandom % 5) == 0;
      level_sel = 8'($urandom) & 8'($urandom);
      auto_eoi  = ($urandom % 3) == 0;
      rot_aeoi  = $urandom % 2;
      spec_mask = ($urandom % 3) == 0;
      spec_nest = ($urandom % 3) == 0;
      for (int c = 0; c < 1200; c++) begin
        int cmd;
        req_in ^= 8'($urandom) & 8'($urandom) & 8'($urandom);
        cmd = $urandom % 10;
        ack = (cmd < 3);
        eoi = (cmd == 3 || cmd == 4);
        eoi_specific = $urandom % 2;
        eoi_rotate = ($urandom % 3) == 0;
        eoi_line = 3'($urandom);
        prio_set = (cmd == 5);
        prio_line = 3'($urandom);
        mask_we = ($urandom % 16) == 0;
        mask_wdata = 8'($urandom) & 8'($urandom);
        model_step();
        cycle();
      end
      ack = 0; eoi = 0; prio_set = 0; mask_we = 0;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule